// File: doc/BRIEF.md
# Configuration State Sequencer

This block steps a programmable device from power-up through initialization, configuration loading, start-up and normal operation. It owns the active-low, wire-ANDed INIT handshake. The line is modelled as a pull-down enable, `init_drive`, plus the sensed level, `init_sense`, so that any device on the line can hold all the others in initialization. It also watches the program and reset requests, samples the mode pins, counts configuration clock ticks against the loaded length, and reacts to the done and error flags of an external frame loader.

INIT, program, reset and the mode pins are asynchronous. Each passes through a two-flop synchronizer before the state logic uses it. Power-good and the frame-loader flags are taken as synchronous.

In a master mode, the device adds a fixed delay before it leaves initialization. This gives slave devices further down the chain time to become ready. The sequencer drives the configuration-time control outputs only while initialization or configuration is in progress.

Top module: `cfg_sequencer`

## Requirements
- R1: After `rst_n` and until `pwr_good` is seen high, the block drives `init_drive`=1. In the same period `done`, `io_enable`, `int_reset_rel` and `ctl_oe` are 0.
- R2: During initialization and configuration, `done`=0, `hdc`=1, `ldc`=0 and `ctl_oe`=1. Each entry into initialization drives `init_drive`=1 for exactly CLR_CYC (4) cycles, after which the line is released.
- R3: `mem_clear` pulses for one cycle, in the last cycle of that drive phase. The pulse is skipped when `keep_mem`=1 and the device has already completed at least one configuration.
- R4: While the synchronized INIT level is low, the block does not leave initialization, so `cnt_clear` is never asserted. A low sensed level during the count restarts the count.
- R5: With `mode_pins[0]`=0 (non-master), the block leaves initialization once INIT, program and reset have all been sensed high for HOLD_CYC (2) consecutive cycles after the synchronizer. `cnt_clear` is high in the last of those cycles, 3 cycles after a released input rises. In that cycle the mode pins are latched onto `mode_cfg`.
- R6: With `mode_pins[0]`=1 (master), the block stays in initialization for MASTER_EXTRA (6) further cycles. `cnt_clear` then comes 9 cycles after the release.
- R7: When `prgm_n` or `reset_n` goes low during configuration, the block aborts to initialization. It does not leave initialization while either of them is low.
- R8: In start-up and operation, `reset_n` has no effect and `done` stays 1. `prgm_n` low returns the block to initialization: `done`=0 and `init_drive`=1 three cycles after the falling edge.
- R9: `cnt_clear` zeroes the tick counter at the entry to configuration. Configuration completes only when the count of `cclk_tick` pulses equals `length_cnt` while `frame_end`=1. `done` rises in the cycle after that.
- R10: `bit_err` during configuration returns the block to initialization. It takes priority over a completion in the same cycle.
- R11: In start-up and operation, `done`=`io_enable`=`int_reset_rel`=1, `ctl_oe`=0, `hdc`=0 and `ldc`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply has settled |
| init_sense | input | 1 | Sensed level of the shared INIT line |
| prgm_n | input | 1 | Active-low program request |
| reset_n | input | 1 | Active-low reset request |
| mode_pins | input | MODE_W | Mode select; bit 0 set means master |
| cclk_tick | input | 1 | One configuration clock tick |
| frame_end | input | 1 | End-of-configuration frame written |
| bit_err | input | 1 | Loader reported a bit error |
| keep_mem | input | 1 | Skip the memory clear on reconfiguration |
| length_cnt | input | CNT_W | Loaded length count |
| init_drive | output | 1 | Pull-down enable for INIT |
| done | output | 1 | Configuration complete |
| hdc | output | 1 | High during configuration |
| ldc | output | 1 | Low during configuration |
| ctl_oe | output | 1 | Output enable for hdc and ldc |
| mem_clear | output | 1 | Configuration memory clear strobe |
| cnt_clear | output | 1 | Tick counter clear on entry to configuration |
| io_enable | output | 1 | User I/Os active |
| int_reset_rel | output | 1 | Internal reset released |
| mode_cfg | output | MODE_W | Mode latched at the start of configuration |

## Verification
The functions that can fall in the same cycle are the completion of a load and a bit error. The bench sets `frame_end` and sends ticks until the count equals the length. In the cycle in which completion becomes true, it raises `bit_err`. The case is judged correct if `done` stays low and `init_drive` goes high again, which shows that the error won and a new initialization has begun.

// File: rtl/cfg_sequencer.sv
module cfg_sequencer #(
  parameter int MODE_W       = 3,
  parameter int CNT_W        = 16,
  parameter int CLR_CYC      = 4,
  parameter int HOLD_CYC     = 2,
  parameter int MASTER_EXTRA = 6,
  parameter int MASTER_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              init_sense,
  input  logic              prgm_n,
  input  logic              reset_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              cclk_tick,
  input  logic              frame_end,
  input  logic              bit_err,
  input  logic              keep_mem,
  input  logic [CNT_W-1:0]  length_cnt,
  output logic              init_drive,
  output logic              done,
  output logic              hdc,
  output logic              ldc,
  output logic              ctl_oe,
  output logic              mem_clear,
  output logic              cnt_clear,
  output logic              io_enable,
  output logic              int_reset_rel,
  output logic [MODE_W-1:0] mode_cfg
);
  localparam int EXIT_CYC = HOLD_CYC + MASTER_EXTRA;
  localparam int HW = $clog2(EXIT_CYC + 1);
  localparam int CW = $clog2(CLR_CYC + 1);

  typedef enum logic [2:0] {S_PWR, S_INIT, S_CFG, S_START, S_OPER} st_t;

  st_t              state;
  logic [1:0]       init_q, prgm_q, rst_q;
  logic [MODE_W-1:0] mode_q1, mode_q2;
  logic [CW-1:0]    clr_cnt;
  logic [HW-1:0]    hi_cnt;
  logic [CNT_W-1:0] cfg_count;
  logic             cfg_once;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      init_q  <= '0;
      prgm_q  <= '0;
      rst_q   <= '0;
      mode_q1 <= '0;
      mode_q2 <= '0;
    end else begin
      init_q  <= {init_q[0], init_sense};
      prgm_q  <= {prgm_q[0], prgm_n};
      rst_q   <= {rst_q[0], reset_n};
      mode_q1 <= mode_pins;
      mode_q2 <= mode_q1;
    end

  logic init_s, prgm_s, reset_s, released, go_ok, hold_pt, leave_init;
  logic cfg_abort, cfg_fail, cfg_ok, in_setup, running;

  assign init_s     = init_q[1];
  assign prgm_s     = prgm_q[1];
  assign reset_s    = rst_q[1];
  assign released   = clr_cnt == CW'(CLR_CYC);
  assign go_ok      = init_s && prgm_s && reset_s;
  assign hold_pt    = hi_cnt == HW'(HOLD_CYC - 1);
  assign leave_init = state == S_INIT && released && go_ok &&
                      ((hold_pt && !mode_q2[MASTER_BIT]) || hi_cnt == HW'(EXIT_CYC - 1));
  assign cfg_abort  = state == S_CFG && (!prgm_s || !reset_s);
  assign cfg_fail   = state == S_CFG && bit_err;
  assign cfg_ok     = state == S_CFG && frame_end && cfg_count == length_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_PWR;
      clr_cnt   <= '0;
      hi_cnt    <= '0;
      cfg_count <= '0;
      cfg_once  <= 1'b0;
      mode_cfg  <= '0;
    end else begin
      case (state)
        S_PWR: if (pwr_good) begin
          state   <= S_INIT;
          clr_cnt <= '0;
          hi_cnt  <= '0;
        end
        S_INIT: begin
          if (released && go_ok && hold_pt) mode_cfg <= mode_q2;
          if (!released) clr_cnt <= clr_cnt + 1'b1;
          else if (leave_init) begin
            state     <= S_CFG;
            cfg_count <= '0;
            hi_cnt    <= '0;
          end else if (go_ok) hi_cnt <= hi_cnt + 1'b1;
          else hi_cnt <= '0;
        end
        S_CFG: begin
          if (cfg_abort || cfg_fail) begin
            state   <= S_INIT;
            clr_cnt <= '0;
            hi_cnt  <= '0;
          end else if (cfg_ok) begin
            state    <= S_START;
            cfg_once <= 1'b1;
          end else if (cclk_tick) cfg_count <= cfg_count + 1'b1;
        end
        S_START, S_OPER: begin
          if (!prgm_s) begin
            state   <= S_INIT;
            clr_cnt <= '0;
            hi_cnt  <= '0;
          end else state <= S_OPER;
        end
        default: state <= S_PWR;
      endcase
    end

  assign in_setup      = state == S_INIT || state == S_CFG;
  assign running       = state == S_START || state == S_OPER;
  assign init_drive    = state == S_PWR || (state == S_INIT && !released);
  assign mem_clear     = state == S_INIT && clr_cnt == CW'(CLR_CYC - 1) && !(keep_mem && cfg_once);
  assign cnt_clear     = leave_init;
  assign hdc           = in_setup;
  assign ldc           = !in_setup;
  assign ctl_oe        = in_setup;
  assign done          = running;
  assign io_enable     = running;
  assign int_reset_rel = running;

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |=> !mem_clear); // R3
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INIT && !init_s) |=> state == S_INIT); // R4
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CFG && !reset_s) |=> state == S_INIT); // R7
  AST_RESET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && prgm_s) |=> done); // R8
  AST_COUNT_START: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> cfg_count == '0); // R9
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == S_CFG)); // R9
  AST_BITERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CFG && bit_err) |=> state == S_INIT); // R10
endmodule

// File: tb/sim_cfg_sequencer.sv
`timescale 1ns/100ps
module sim_cfg_sequencer;
  logic clk = 0, rst_n = 0, pwr_good = 0, ext_hold = 1, prgm_n = 1, reset_n = 1;
  logic [2:0] mode_pins = 3'b010;
  logic cclk_tick = 0, frame_end = 0, bit_err = 0, keep_mem = 1;
  logic [15:0] length_cnt = 16'd5;
  logic init_sense, init_drive, done, hdc, ldc, ctl_oe, mem_clear, cnt_clear, io_enable, int_reset_rel;
  logic [2:0] mode_cfg;
  int checks = 0, fails = 0, mc_cnt = 0, cc_cnt = 0, idrv_cnt = 0;
  int k, s_mc, s_cc, s_id, zero_done;

  always #2.5 clk = ~clk;
  assign init_sense = !(init_drive || ext_hold);

  cfg_sequencer u0 (.clk, .rst_n, .pwr_good, .init_sense, .prgm_n, .reset_n, .mode_pins,
    .cclk_tick, .frame_end, .bit_err, .keep_mem, .length_cnt, .init_drive, .done, .hdc,
    .ldc, .ctl_oe, .mem_clear, .cnt_clear, .io_enable, .int_reset_rel, .mode_cfg);

  always @(posedge clk) begin
    if (mem_clear) mc_cnt++;
    if (cnt_clear) cc_cnt++;
    if (init_drive && ctl_oe) idrv_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    cclk_tick = 1; cyc(1); cclk_tick = 0;
  endtask

  task automatic measure(output int kk);
    kk = 0;
    do begin
      @(posedge clk); @(negedge clk); kk++;
    end while (!cnt_clear && kk < 40);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(5);
    chk(init_drive && !done && !io_enable && !int_reset_rel && !ctl_oe, "R1 power-up outputs",
        {init_drive, done, io_enable, int_reset_rel, ctl_oe}, 5'b10000);
    pwr_good = 1; cyc(20);
    chk(!done && hdc && !ldc && ctl_oe && !init_drive, "R2 init outputs",
        {done, hdc, ldc, ctl_oe, init_drive}, 5'b01010);
    chk(idrv_cnt == 4, "R2 drive length", idrv_cnt, 4);
    chk(mc_cnt == 1, "R3 first clear", mc_cnt, 1);
    chk(cc_cnt == 0, "R4 held low externally", cc_cnt, 0);

    ext_hold = 0; measure(k);
    chk(k == 3, "R5 non-master exit delay", k, 3);
    cyc(1);
    chk(mode_cfg == 3'b010, "R5 mode latched", mode_cfg, 2);

    frame_end = 1;
    repeat (4) tick();
    cyc(2);
    chk(!done, "R9 short count", done, 0);
    tick(); cyc(1);
    chk(done && io_enable && int_reset_rel && !ctl_oe && !hdc && ldc, "R11 running outputs",
        {done, io_enable, int_reset_rel, ctl_oe, hdc, ldc}, 6'b111001);

    reset_n = 0; zero_done = 0;
    repeat (10) begin cyc(1); if (!done) zero_done++; end
    reset_n = 1;
    chk(zero_done == 0, "R8 reset ignored", zero_done, 0);

    mode_pins = 3'b001; frame_end = 0; s_mc = mc_cnt;
    prgm_n = 0; cyc(3);
    chk(!done && init_drive, "R8 prgm reconfig", {done, init_drive}, 2'b01);
    cyc(10);
    chk(mc_cnt == s_mc, "R3 clear skipped", mc_cnt - s_mc, 0);
    prgm_n = 1; measure(k);
    chk(k == 9, "R6 master exit delay", k, 9);
    cyc(1);
    chk(mode_cfg == 3'b001, "R6 master mode latched", mode_cfg, 1);

    length_cnt = 16'd3;
    repeat (3) tick();
    cyc(3);
    chk(!done, "R9 frame end required", done, 0);
    keep_mem = 0; s_mc = mc_cnt; s_cc = cc_cnt; s_id = idrv_cnt;
    reset_n = 0; cyc(20);
    chk(idrv_cnt - s_id == 4, "R2 drive after abort", idrv_cnt - s_id, 4);
    chk(mc_cnt - s_mc == 1, "R3 clear on reconfig", mc_cnt - s_mc, 1);
    chk(cc_cnt == s_cc && !done, "R7 abort blocks start", cc_cnt - s_cc, 0);
    reset_n = 1; measure(k);
    chk(k == 9, "R7 restart after release", k, 9);
    cyc(1);

    length_cnt = 16'd2; frame_end = 1;
    tick(); tick();
    bit_err = 1; cyc(1); bit_err = 0;
    chk(!done && init_drive, "R10 error beats completion", {done, init_drive}, 2'b01);

    ext_hold = 1; cyc(10); s_cc = cc_cnt;
    ext_hold = 0; cyc(5); ext_hold = 1; cyc(1); ext_hold = 0;
    chk(cc_cnt == s_cc, "R4 glitch restarts count", cc_cnt - s_cc, 0);
    measure(k);
    chk(k == 9, "R6 delay after restart", k, 9);
    cyc(1);
    length_cnt = 16'd1;
    tick(); cyc(1);
    chk(done, "R9 completion", done, 1);
    finish_up();
  end
endmodule